// File: doc/BRIEF.md
# Cell-Handshake Transmit Port for a 16-bit ATM Cell Bus

This block is the transmit half of an ATM-layer cell bus that uses a cell-level handshake toward a PHY framer. Upstream logic pushes 16-bit words into an internal FIFO. The block moves them out one word per clock on a 16-bit bus and marks each word as valid with an active-low enable. It raises a start-of-cell marker on the first word of every cell and drives an odd-parity bit with each word. A cell is a fixed number of words, 27 by default: 53 octets plus one pad octet.

The framer drives a full indication back to the block. The block samples it only at a cell boundary. While the block is idle, it samples it on every clock edge. While a cell is in flight, it samples it only on the edge that ends the cell's last word. A cell that has started therefore always runs to completion without a gap. A new cell starts only when the framer was not full at the deciding edge and a whole cell is already waiting in the FIFO. Otherwise the enable goes high between cells.

The sequencer has two states. `ST_IDLE` holds the enable high. `ST_SEND` presents one word of a cell per cycle. The transitions are:
- **start** (`ST_IDLE` to `ST_SEND`) when a whole cell is queued and the full indication is low.
- **advance** (stay in `ST_SEND` at the next word) on every word before the last.
- **chain** (stay in `ST_SEND` at word 0) on the last word when a new cell may start.
- **stop** (`ST_SEND` to `ST_IDLE`) on the last word when the framer is full or no whole cell is queued.

Top module: `cell_tx_link`

## Requirements
- R1: After a synchronous active-low reset, `tx_en_n` is 1, `tx_soc` is 0, `tx_data` is 0, `tx_par` is 1 and the FIFO is empty (`wr_full` is 0).
- R2: A cell never starts while fewer than CELL_WORDS words are held in the FIFO. The enable stays high even though some words are queued.
- R3: When `phy_full` is sampled low at a rising edge while a whole cell is queued and the port is idle, `tx_en_n` is 0 in the cycle after that edge. `tx_en_n` never falls unless `phy_full` was low at the previous edge.
- R4: `tx_soc` is 1 only together with `tx_en_n` = 0, and only on the first word of each cell.
- R5: The words of a cell appear in FIFO order, one per cycle, in CELL_WORDS consecutive enabled cycles.
- R6: In every enabled cycle the 17 bits {`tx_data`, `tx_par`} hold an odd number of ones.
- R7: Once a cell has started, `phy_full` has no effect on any word except the last. The cell still completes in CELL_WORDS consecutive cycles.
- R8: If `phy_full` is 1 at the edge ending a cell's last word, `tx_en_n` is 1 in the next cycle. A new cell starts one cycle after `phy_full` is next sampled low.
- R9: With two whole cells queued and `phy_full` low, the second cell's first word follows the first cell's last word in the very next cycle.
- R10: If fewer than CELL_WORDS words remain at the end of a cell, `tx_en_n` goes to 1 and stays there.
- R11: While `tx_en_n` is 1, `tx_data` and `tx_par` keep their last value and no FIFO word is consumed. The next cell starts with the oldest queued word.
- R12: `wr_full` is 1 when FIFO_DEPTH words are held. A push while full is dropped and never appears on the bus.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock; all activity on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_en | input | 1 | Push one word into the transmit FIFO |
| wr_data | input | DATA_W | Word to push |
| wr_full | output | 1 | FIFO holds FIFO_DEPTH words; pushes are dropped |
| phy_full | input | 1 | Framer full indication, active high |
| tx_en_n | output | 1 | Active-low enable: the bus carries a valid word |
| tx_soc | output | 1 | High on the first word of each cell |
| tx_data | output | DATA_W | Transmit word |
| tx_par | output | 1 | Odd parity over `tx_data` |

## Verification
The sequencer is tried with several patterns:
- a queue one word short of a cell, then completed by a single push, which separates the completeness test from simply having data;
- a full indication held through a cell's middle words, which shows it is ignored there;
- an over-filled FIFO drained as two back-to-back cells, which exposes both an idle gap at the seam and the dropping of overflow words;
- a full indication still high on the last word, which must open a gap that ends exactly one cycle after the indication falls.

Word values count upward, so the order, loss or repetition of any word shows up directly on the bus.

// File: rtl/cell_tx_pkg.sv
package cell_tx_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SEND = 1'b1
    } tx_state_e;

endpackage

// File: rtl/cell_fifo.sv
module cell_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 64
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [W-1:0]               push_data,
    input  logic                       pop,
    output logic [W-1:0]               head,
    output logic [$clog2(DEPTH+1)-1:0] count,
    output logic                       full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] DEPTH_C = CW'(DEPTH);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic          push_ok;

    assign full    = (count == DEPTH_C);
    assign push_ok = push && !full;
    assign head    = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            unique case ({push_ok, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/cell_tx_seq.sv
module cell_tx_seq
    import cell_tx_pkg::*;
#(
    parameter int W          = 16,
    parameter int CELL_WORDS = 27
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cell_ready,
    input  logic         phy_full,
    input  logic [W-1:0] head,
    output logic         pop,
    output logic         tx_en_n,
    output logic         tx_soc,
    output logic [W-1:0] tx_data,
    output logic         tx_par
);
    localparam int IW = $clog2(CELL_WORDS);
    localparam logic [IW-1:0] LAST_IDX = IW'(CELL_WORDS - 1);

    tx_state_e     state_q, state_d;
    logic [IW-1:0] idx_q, idx_d;
    logic          load;
    logic          first;
    logic          start_ok;

    assign start_ok = cell_ready && !phy_full;

    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        load    = 1'b0;
        first   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start_ok) begin        // start
                    state_d = ST_SEND;
                    idx_d   = '0;
                    load    = 1'b1;
                    first   = 1'b1;
                end
            end
            ST_SEND: begin
                if (idx_q != LAST_IDX) begin   // advance
                    idx_d = idx_q + 1'b1;
                    load  = 1'b1;
                end else if (start_ok) begin   // chain
                    idx_d = '0;
                    load  = 1'b1;
                    first = 1'b1;
                end else begin                 // stop
                    state_d = ST_IDLE;
                    idx_d   = '0;
                end
            end
            default: begin
                state_d = ST_IDLE;
                idx_d   = '0;
            end
        endcase
    end

    assign pop = load;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_en_n <= 1'b1;
            tx_soc  <= 1'b0;
            tx_data <= '0;
            tx_par  <= 1'b1;
        end else begin
            tx_en_n <= !load;
            tx_soc  <= first;
            if (load) begin
                tx_data <= head;
                tx_par  <= ~^head;
            end
        end
    end

endmodule

// File: rtl/cell_tx_link.sv
module cell_tx_link #(
    parameter int DATA_W     = 16,
    parameter int CELL_WORDS = 27,
    parameter int FIFO_DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output logic              wr_full,
    input  logic              phy_full,
    output logic              tx_en_n,
    output logic              tx_soc,
    output logic [DATA_W-1:0] tx_data,
    output logic              tx_par
);
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [CNT_W-1:0] CELL_CNT = CNT_W'(CELL_WORDS);

    logic [DATA_W-1:0] head;
    logic [CNT_W-1:0]  count;
    logic              pop;
    logic              cell_ready;

    assign cell_ready = (count >= CELL_CNT);

    cell_fifo #(
        .W     (DATA_W),
        .DEPTH (FIFO_DEPTH)
    ) fifo_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_en),
        .push_data (wr_data),
        .pop       (pop),
        .head      (head),
        .count     (count),
        .full      (wr_full)
    );

    cell_tx_seq #(
        .W          (DATA_W),
        .CELL_WORDS (CELL_WORDS)
    ) seq_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cell_ready (cell_ready),
        .phy_full   (phy_full),
        .head       (head),
        .pop        (pop),
        .tx_en_n    (tx_en_n),
        .tx_soc     (tx_soc),
        .tx_data    (tx_data),
        .tx_par     (tx_par)
    );

endmodule

// File: rtl/cell_tx_link_chk.sv
module cell_tx_link_chk #(
    parameter int DATA_W     = 16,
    parameter int CELL_WORDS = 27
) (
    input logic              clk,
    input logic              rst_n,
    input logic              phy_full,
    input logic              tx_en_n,
    input logic              tx_soc,
    input logic [DATA_W-1:0] tx_data,
    input logic              tx_par
);
    localparam int PW = $clog2(CELL_WORDS + 1);
    localparam logic [PW-1:0] FULL_P = PW'(CELL_WORDS);
    localparam logic [PW-1:0] LAST_P = PW'(CELL_WORDS - 1);

    // words already shown in the current cell, before this cycle
    logic [PW-1:0] pos_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (!tx_en_n) begin
            pos_q <= tx_soc ? PW'(1) : pos_q + 1'b1;
        end
    end

    assert_soc_needs_en_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |-> !tx_en_n);

    assert_soc_at_boundary_R4: assert property (@(posedge clk) disable iff (!rst_n)
        tx_soc |-> (pos_q == '0 || pos_q == FULL_P));

    assert_start_after_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_en_n) |-> (tx_soc && !$past(phy_full)));

    assert_cell_unbroken_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_n |-> (pos_q == '0 || pos_q == FULL_P));

    assert_mid_word_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_n && !tx_soc) |-> (pos_q != '0 && pos_q < FULL_P));

    assert_full_stops_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_n && pos_q == LAST_P && phy_full) |=> tx_en_n);

    assert_odd_parity_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en_n |-> (^{tx_data, tx_par} == 1'b1));

    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_en_n |-> ($stable(tx_data) && $stable(tx_par)));

endmodule

bind cell_tx_link cell_tx_link_chk #(
    .DATA_W     (DATA_W),
    .CELL_WORDS (CELL_WORDS)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .phy_full (phy_full),
    .tx_en_n  (tx_en_n),
    .tx_soc   (tx_soc),
    .tx_data  (tx_data),
    .tx_par   (tx_par)
);

// File: tb/cell_tx_link_tb_top.sv
`timescale 1ns/1ps
module cell_tx_link_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int DW         = 16;
    localparam int CELL       = 27;
    localparam int DEPTH      = 64;
    localparam int WDOG       = 20000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          wr_full;
    logic          phy_full = 1'b0;
    logic          tx_en_n;
    logic          tx_soc;
    logic [DW-1:0] tx_data;
    logic          tx_par;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic [DW-1:0] log_d [1024];
    logic          log_s [1024];
    int            log_c [1024];
    int            log_n   = 0;
    int            par_bad = 0;

    cell_tx_link #(.DATA_W(DW), .CELL_WORDS(CELL), .FIFO_DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .wr_full(wr_full), .phy_full(phy_full), .tx_en_n(tx_en_n),
        .tx_soc(tx_soc), .tx_data(tx_data), .tx_par(tx_par)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    // bus monitor, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !tx_en_n) begin
            log_d[log_n] = tx_data;
            log_s[log_n] = tx_soc;
            log_c[log_n] = cyc;
            log_n = log_n + 1;
            if (^{tx_data, tx_par} !== 1'b1) par_bad = par_bad + 1;
        end
    end

    always @(posedge clk) begin
        if (cyc > WDOG && !done) begin
            checks = checks + 1;
            fails  = fails + 1;
            $display("FAIL watchdog: act=%0d cycles exp<=%0d", cyc, WDOG);
            $display("[TB] %0d tests run, %0d failed", checks, fails);
            $finish;
        end
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s %s: act=0x%0h exp=0x%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic push_words(input int base, input int n);
        for (int i = 0; i < n; i++) begin
            wr_en   = 1'b1;
            wr_data = DW'(base + i);
            tick();
        end
        wr_en = 1'b0;
    endtask

    // n logged words starting at s: consecutive cycles, soc only at cell heads
    task automatic check_run(input int s, input int n, input string req);
        int bad_c = 0;
        int bad_s = 0;
        for (int i = 0; i < n; i++) begin
            if (log_c[s+i] != log_c[s] + i) bad_c++;
            if (log_s[s+i] != (((i % CELL) == 0) ? 1'b1 : 1'b0)) bad_s++;
        end
        check(bad_c == 0, req, "non-consecutive words", bad_c, 0);
        check(bad_s == 0, "R4", "misplaced soc", bad_s, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) tick();
        rst_n = 1'b1;
        tick();
        check(tx_en_n == 1'b1, "R1", "en_n after reset", int'(tx_en_n), 1);
        check(tx_soc == 1'b0, "R1", "soc after reset", int'(tx_soc), 0);
        check(tx_data == '0, "R1", "data after reset", int'(tx_data), 0);
        check(tx_par == 1'b1, "R1", "par after reset", int'(tx_par), 1);
        check(wr_full == 1'b0, "R1", "full after reset", int'(wr_full), 0);
    endtask

    task automatic t_partial_then_complete();
        int bad = 0;
        log_n = 0; par_bad = 0;
        phy_full = 1'b0;
        push_words(16'h1000, CELL - 1);
        repeat (10) tick();
        check(log_n == 0, "R2", "words sent with partial cell", log_n, 0);
        push_words(16'h1000 + CELL - 1, 1);
        repeat (35) tick();
        check(log_n == CELL, "R5", "word count of single cell", log_n, CELL);
        for (int i = 0; i < CELL; i++) if (log_d[i] != DW'(16'h1000 + i)) bad++;
        check(bad == 0, "R5", "word order mismatches", bad, 0);
        check_run(0, CELL, "R5");
        check(par_bad == 0, "R6", "words with even parity", par_bad, 0);
        check(tx_en_n == 1'b1, "R10", "en_n with empty FIFO", int'(tx_en_n), 1);
        check(tx_data == DW'(16'h1000 + CELL - 1), "R11", "held data",
              int'(tx_data), 16'h1000 + CELL - 1);
    endtask

    task automatic t_mid_cell_full();
        int guard = 0;
        log_n = 0;
        phy_full = 1'b0;
        push_words(16'h3000, CELL);
        while (!tx_soc && guard < 50) begin tick(); guard++; end
        repeat (3) tick();
        phy_full = 1'b1;
        repeat (15) tick();
        phy_full = 1'b0;
        repeat (20) tick();
        check(log_n == CELL, "R7", "words in cell with mid-cell full", log_n, CELL);
        check_run(0, CELL, "R7");
    endtask

    task automatic t_overflow_back_to_back();
        int bad = 0;
        int c0;
        log_n = 0;
        phy_full = 1'b1;
        push_words(16'h5000, DEPTH + 6);
        check(wr_full == 1'b1, "R12", "full flag at depth", int'(wr_full), 1);
        check(log_n == 0, "R3", "words sent while framer full", log_n, 0);
        phy_full = 1'b0;
        c0 = cyc;
        repeat (80) tick();
        check(log_n == 2 * CELL, "R9", "words in two cells", log_n, 2 * CELL);
        check(log_c[0] == c0 + 1, "R3", "start cycle after clear", log_c[0], c0 + 1);
        for (int i = 0; i < 2 * CELL; i++) if (log_d[i] != DW'(16'h5000 + i)) bad++;
        check(bad == 0, "R9", "order mismatches across cells", bad, 0);
        check_run(0, 2 * CELL, "R9");
        check(tx_en_n == 1'b1, "R10", "en_n with 10 words left", int'(tx_en_n), 1);
        check(wr_full == 1'b0, "R12", "full flag after drain", int'(wr_full), 0);
    endtask

    task automatic t_full_at_boundary();
        int bad = 0;
        int guard = 0;
        int c0;
        int rem = DEPTH - 2 * CELL;   // 10 leftover words from the previous scenario
        log_n = 0;
        phy_full = 1'b1;
        push_words(16'h7000, 2 * CELL - rem);
        phy_full = 1'b0;
        while (!tx_soc && guard < 50) begin tick(); guard++; end
        repeat (10) tick();
        phy_full = 1'b1;
        guard = 0;
        while (!tx_en_n && guard < 50) begin tick(); guard++; end
        repeat (5) tick();
        check(tx_en_n == 1'b1, "R8", "en_n with full on last word", int'(tx_en_n), 1);
        check(log_n == CELL, "R8", "words before the gap", log_n, CELL);
        check(tx_data == DW'(16'h7000 + CELL - rem - 1), "R11", "data held in gap",
              int'(tx_data), 16'h7000 + CELL - rem - 1);
        for (int i = 0; i < CELL; i++) begin
            if (i < rem) begin
                if (log_d[i] != DW'(16'h5000 + 2 * CELL + i)) bad++;
            end else begin
                if (log_d[i] != DW'(16'h7000 + i - rem)) bad++;
            end
        end
        check(bad == 0, "R12", "dropped words reappeared", bad, 0);
        phy_full = 1'b0;
        c0 = cyc;
        repeat (40) tick();
        check(log_n == 2 * CELL, "R8", "words after resume", log_n, 2 * CELL);
        check(log_c[CELL] == c0 + 1, "R8", "resume cycle", log_c[CELL], c0 + 1);
        check(log_c[CELL] > log_c[CELL-1] + 1, "R8", "gap cycle", log_c[CELL], log_c[CELL-1] + 2);
        check(log_d[CELL] == DW'(16'h7000 + CELL - rem), "R11", "first word after gap",
              int'(log_d[CELL]), 16'h7000 + CELL - rem);
        check_run(CELL, CELL, "R5");
    endtask

    initial begin
        t_reset();
        t_partial_then_complete();
        t_mid_cell_full();
        t_overflow_back_to_back();
        t_full_at_boundary();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", checks, fails);
        $finish;
    end

endmodule